// File: doc/BRIEF.md
# RC4 Keystream Coprocessor

This block is a byte-serial stream-cipher engine for protecting legacy wireless LAN payloads. It keeps the 256-byte permutation state in one behavioural 256x8 dual-port RAM. A key of 5 to 16 bytes is written into a small key file. A start strobe then runs a fixed setup of 1152 clock cycles. The first 128 cycles fill the state with the identity permutation, two entries per cycle. The remaining 1024 cycles run the key schedule at four cycles per state index.

After setup the engine takes one data byte at a time over a valid/ready handshake. For each byte it advances the generator, swaps two state entries and returns the data byte XORed with the next keystream byte. Encryption and decryption are therefore the same operation. Every frame pays the full setup again: a new start discards the old state and restarts the keystream at its first byte.

Top module: `rc4_stream_engine`

## Requirements
- R1: After reset, busy, in_ready and out_valid are all low, and in_ready stays low until a setup has completed.
- R2: A start sampled high while busy is low raises busy on the next cycle. busy then stays high for exactly 1152 consecutive cycles: 128 for the identity fill and 1024 for the key schedule.
- R3: A start sampled while busy is high is ignored, so the running setup is neither restarted nor lengthened.
- R4: in_ready is low whenever busy is high. After setup it is high whenever no byte is in flight.
- R5: For each accepted byte, out_data equals in_data XOR the next byte of standard RC4 output. The key is bytes 0..len-1 of the key file, and both generator indices start at 0 after setup.
- R6: key_len is sampled at start. A value below 5 acts as 5 and a value above 16 acts as 16. During the schedule the key byte index wraps modulo the effective length.
- R7: key_we writes key_byte into slot key_idx (0..15) only while busy is low. Writes made while busy is high leave the key file unchanged.
- R8: An accepted byte (in_valid and in_ready high at a rising edge) makes out_valid high for exactly one cycle, starting at the fourth rising edge after the accepting edge. in_ready is low from the accepting edge until that same fourth edge.
- R9: Each new start reruns the full setup and restarts the keystream, so feeding ciphertext after a restart with the same key returns the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Write strobe for the key file |
| key_idx | input | 4 | Key file slot to write |
| key_byte | input | 8 | Key byte to write |
| key_len | input | 5 | Requested key length, sampled at start |
| start | input | 1 | Begin identity fill and key schedule |
| busy | output | 1 | High during the 1152-cycle setup |
| in_valid | input | 1 | A data byte is offered |
| in_ready | output | 1 | Engine can accept a data byte |
| in_data | input | 8 | Payload byte in |
| out_valid | output | 1 | One-cycle strobe for a result byte |
| out_data | output | 8 | Payload byte XOR keystream |

## Verification
The latency property assumes that no start arrives while a byte is in flight. An abort in that window would legitimately cancel the pending result. The bench therefore starts a new frame only after the last result strobe. The busy-length check assumes that reset is not asserted in the middle of a setup, and the bench applies reset only once, at time zero. The bench deliberately pulses start and key writes inside a running setup, since the engine must ignore those inputs.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
  localparam int S_AW       = 8;
  localparam int S_DEPTH    = 1 << S_AW;
  localparam int KEY_SLOTS  = 16;
  localparam int KEY_AW     = $clog2(KEY_SLOTS);
  localparam int KLEN_W     = KEY_AW + 1;
  localparam int KEY_MIN    = 5;
  localparam int FILL_W     = S_AW - 1;
  localparam int KSA_STEPS  = 4;
  localparam int KSA_W      = S_AW + $clog2(KSA_STEPS);
  localparam int FILL_CYC   = S_DEPTH / 2;
  localparam int KSA_CYC    = S_DEPTH * KSA_STEPS;
  localparam int INIT_CYC   = FILL_CYC + KSA_CYC;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FILL, SEQ_KSA} seq_t;
  typedef enum logic [2:0] {PG_IDLE, PG_LDJ, PG_SWAP, PG_IDX, PG_OUT} pg_t;

  // Effective key length: requested value forced into [KEY_MIN, KEY_SLOTS].
  function automatic logic [KLEN_W-1:0] clamp_len(input logic [KLEN_W-1:0] raw);
    if (raw < KLEN_W'(KEY_MIN))   return KLEN_W'(KEY_MIN);
    if (raw > KLEN_W'(KEY_SLOTS)) return KLEN_W'(KEY_SLOTS);
    return raw;
  endfunction

  // Schedule / generator j update (key byte is zero in the generator).
  function automatic logic [S_AW-1:0] next_j(input logic [S_AW-1:0] j,
                                             input logic [S_AW-1:0] s_i,
                                             input logic [7:0]      k);
    return j + s_i + k;
  endfunction

  // Address of the output byte from the two swapped entries.
  function automatic logic [S_AW-1:0] out_index(input logic [S_AW-1:0] a,
                                                input logic [S_AW-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/rc4_perm_ram.sv
module rc4_perm_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // Registered reads, read-before-write; port B wins an address clash.
  always_ff @(posedge clk) begin
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
    if (a_we) mem[a_addr] <= a_wd;
    if (b_we) mem[b_addr] <= b_wd;
  end
endmodule

// File: rtl/rc4_key_file.sv
module rc4_key_file
  import rc4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [KEY_AW-1:0] wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic              len_load,
  input  logic [KLEN_W-1:0] len_raw,
  input  logic [KEY_AW-1:0] rd_idx,
  output logic [7:0]        rd_byte,
  output logic [KLEN_W-1:0] len_eff
);
  logic [7:0] slot_q [KEY_SLOTS];

  for (genvar g = 0; g < KEY_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         slot_q[g] <= '0;
      else if (wr_en && !lock && wr_idx == KEY_AW'(g))    slot_q[g] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        len_eff <= KLEN_W'(KEY_MIN);
    else if (len_load) len_eff <= clamp_len(len_raw);
  end

  assign rd_byte = slot_q[rd_idx];
endmodule

// File: rtl/rc4_init_seq.sv
module rc4_init_seq
  import rc4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             start_acc,
  output logic             busy,
  output logic             fill_act,
  output logic [FILL_W-1:0] fill_idx,
  output logic             ksa_act,
  output logic [S_AW-1:0]  ksa_idx,
  output logic [1:0]       ksa_sub,
  output logic             setup_last
);
  seq_t              st_q;
  logic [FILL_W-1:0] fcnt_q;
  logic [KSA_W-1:0]  kcnt_q;

  assign busy       = (st_q != SEQ_IDLE);
  assign start_acc  = start && !busy;
  assign fill_act   = (st_q == SEQ_FILL);
  assign ksa_act    = (st_q == SEQ_KSA);
  assign fill_idx   = fcnt_q;
  assign ksa_idx    = kcnt_q[KSA_W-1:2];
  assign ksa_sub    = kcnt_q[1:0];
  assign setup_last = ksa_act && (&kcnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      fcnt_q <= '0;
      kcnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start_acc) begin
          st_q   <= SEQ_FILL;
          fcnt_q <= '0;
          kcnt_q <= '0;
        end
        SEQ_FILL: begin
          fcnt_q <= fcnt_q + 1'b1;
          if (&fcnt_q) st_q <= SEQ_KSA;
        end
        SEQ_KSA: begin
          kcnt_q <= kcnt_q + 1'b1;
          if (&kcnt_q) st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rc4_stream_engine.sv
module rc4_stream_engine
  import rc4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [KEY_AW-1:0] key_idx,
  input  logic [7:0]        key_byte,
  input  logic [KLEN_W-1:0] key_len,
  input  logic              start,
  output logic              busy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  output logic [7:0]        out_data
);
  logic              start_acc, fill_act, ksa_act, setup_last;
  logic [FILL_W-1:0] fill_idx;
  logic [S_AW-1:0]   ksa_idx;
  logic [1:0]        ksa_sub;

  logic [KEY_AW-1:0] kpos_q;
  logic [7:0]        kbyte;
  logic [KLEN_W-1:0] len_eff;

  logic [S_AW-1:0] a_addr, b_addr, a_rd, b_rd;
  logic [7:0]      a_wd, b_wd;
  logic            a_we, b_we;

  logic [S_AW-1:0] i_q, j_q, si_q, sj_q;
  logic [7:0]      dat_q;
  logic            keyed_q;
  pg_t             pg_q;

  logic [S_AW-1:0] ksa_jn, pg_jn;
  logic            byte_acc, kpos_wrap;

  rc4_init_seq u_seq (
    .clk, .rst_n, .start, .start_acc, .busy, .fill_act, .fill_idx,
    .ksa_act, .ksa_idx, .ksa_sub, .setup_last
  );

  rc4_key_file u_key (
    .clk, .rst_n, .lock(busy), .wr_en(key_we), .wr_idx(key_idx),
    .wr_byte(key_byte), .len_load(start_acc), .len_raw(key_len),
    .rd_idx(kpos_q), .rd_byte(kbyte), .len_eff
  );

  rc4_perm_ram #(.AW(S_AW), .DW(8)) u_ram (
    .clk, .a_addr, .a_we, .a_wd, .a_rd, .b_addr, .b_we, .b_wd, .b_rd
  );

  assign ksa_jn    = next_j(j_q, a_rd, kbyte);
  assign pg_jn     = next_j(j_q, a_rd, 8'd0);
  assign in_ready  = keyed_q && !busy && (pg_q == PG_IDLE);
  assign byte_acc  = in_valid && in_ready;
  assign kpos_wrap = ({1'b0, kpos_q} == len_eff - 1'b1);

  // RAM port steering: fill, schedule and generator never overlap.
  always_comb begin
    a_addr = '0; a_we = 1'b0; a_wd = '0;
    b_addr = '0; b_we = 1'b0; b_wd = '0;
    if (fill_act) begin
      a_addr = {fill_idx, 1'b0}; a_we = 1'b1; a_wd = {fill_idx, 1'b0};
      b_addr = {fill_idx, 1'b1}; b_we = 1'b1; b_wd = {fill_idx, 1'b1};
    end else if (ksa_act) begin
      unique case (ksa_sub)
        2'd0: a_addr = ksa_idx;
        2'd1: b_addr = ksa_jn;
        2'd2: begin
          a_addr = ksa_idx; a_we = 1'b1; a_wd = b_rd;
          b_addr = j_q;     b_we = 1'b1; b_wd = si_q;
        end
        default: ;
      endcase
    end else begin
      unique case (pg_q)
        PG_IDLE: a_addr = i_q + 1'b1;
        PG_LDJ:  b_addr = pg_jn;
        PG_SWAP: begin
          a_addr = i_q; a_we = 1'b1; a_wd = b_rd;
          b_addr = j_q; b_we = 1'b1; b_wd = si_q;
        end
        PG_IDX:  a_addr = out_index(si_q, sj_q);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0; j_q <= '0; si_q <= '0; sj_q <= '0;
      dat_q <= '0; kpos_q <= '0; keyed_q <= 1'b0;
      pg_q <= PG_IDLE; out_valid <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start_acc) begin
        i_q <= '0; j_q <= '0; kpos_q <= '0;
        keyed_q <= 1'b0; pg_q <= PG_IDLE;
      end else if (ksa_act) begin
        if (ksa_sub == 2'd1) begin
          si_q <= a_rd;
          j_q  <= ksa_jn;
        end
        if (ksa_sub == 2'd3) kpos_q <= kpos_wrap ? '0 : kpos_q + 1'b1;
        if (setup_last) begin
          i_q <= '0; j_q <= '0; keyed_q <= 1'b1;
        end
      end else if (!busy) begin
        unique case (pg_q)
          PG_IDLE: if (byte_acc) begin
            i_q <= i_q + 1'b1; dat_q <= in_data; pg_q <= PG_LDJ;
          end
          PG_LDJ:  begin si_q <= a_rd; j_q <= pg_jn; pg_q <= PG_SWAP; end
          PG_SWAP: begin sj_q <= b_rd; pg_q <= PG_IDX; end
          PG_IDX:  pg_q <= PG_OUT;
          PG_OUT:  begin
            out_data <= dat_q ^ a_rd; out_valid <= 1'b1; pg_q <= PG_IDLE;
          end
          default: pg_q <= PG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rc4_stream_chk.sv
module rc4_stream_chk
  import rc4_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              setup_last,
  input logic [S_AW-1:0]   gen_i,
  input logic [S_AW-1:0]   gen_j,
  input logic [KLEN_W-1:0] len_eff
);
  logic [$clog2(INIT_CYC+2)-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !in_ready && !out_valid));
  // R2
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == INIT_CYC));
  // R4
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  // R5
  gen_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_last |=> (gen_i == '0 && gen_j == '0));
  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_eff >= KLEN_W'(KEY_MIN) && len_eff <= KLEN_W'(KEY_SLOTS)));
  // R8
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready, 5) |-> out_valid);
  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind rc4_stream_engine rc4_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .setup_last(setup_last), .gen_i(i_q), .gen_j(j_q), .len_eff(len_eff)
);

// File: tb/test_rc4_stream_engine.sv
module test_rc4_stream_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_we = 1'b0;
  logic [3:0] key_idx = '0;
  logic [7:0] key_byte = '0;
  logic [4:0] key_len = 5'd5;
  logic       start = 1'b0;
  logic       busy, in_ready, out_valid;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0, out_data;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int ref_key [16];
  int ref_len;
  int ref_ks [64];
  int pt [64];
  int ct [64];

  rc4_stream_engine i_rc4_stream_engine (
    .clk, .rst_n, .key_we, .key_idx, .key_byte, .key_len, .start, .busy,
    .in_valid, .in_ready, .in_data, .out_valid, .out_data
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL R2 watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench's own RC4: schedule then generator, plain integer arithmetic.
  task automatic ref_gen(input int n);
    int s [256];
    int a, b, t;
    for (int k = 0; k < 256; k++) s[k] = k;
    b = 0;
    for (int k = 0; k < 256; k++) begin
      b = (b + s[k] + ref_key[k % ref_len]) % 256;
      t = s[k]; s[k] = s[b]; s[b] = t;
    end
    a = 0; b = 0;
    for (int m = 0; m < n; m++) begin
      a = (a + 1) % 256;
      b = (b + s[a]) % 256;
      t = s[a]; s[a] = s[b]; s[b] = t;
      ref_ks[m] = s[(s[a] + s[b]) % 256];
    end
  endtask

  task automatic load_key(input int raw_len);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      key_we = 1'b1; key_idx = 4'(k); key_byte = 8'(ref_key[k]);
    end
    @(negedge clk);
    key_we = 1'b0;
    key_len = 5'(raw_len);
    ref_len = (raw_len < 5) ? 5 : (raw_len > 16) ? 16 : raw_len;
  endtask

  task automatic run_setup(input string req);
    int cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
    check(req, cnt, 1152);
    check("R4 ready after setup", in_ready, 1);
  endtask

  task automatic xfer(input int d, output int q, output int lat);
    int g = 0;
    int t_acc;
    @(negedge clk);
    while (!in_ready && g < 100) begin g++; @(negedge clk); end
    in_valid = 1'b1; in_data = 8'(d);
    @(negedge clk);
    in_valid = 1'b0;
    t_acc = cyc;
    g = 0;
    while (!out_valid && g < 50) begin g++; @(negedge clk); end
    q = out_data;
    lat = cyc - t_acc;
    @(negedge clk);
    check("R8 single pulse", out_valid, 0);
  endtask

  task automatic run_frame(input int n, input string req);
    int q, lat;
    ref_gen(n);
    for (int m = 0; m < n; m++) begin
      xfer(pt[m], q, lat);
      ct[m] = q;
      check(req, q, (pt[m] ^ ref_ks[m]) & 8'hff);
      if (m == 0) check("R8 latency", lat, 4);
    end
  endtask

  initial begin
    int q, lat, cnt;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 in_ready", in_ready, 0);
    check("R1 out_valid", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 not ready unkeyed", in_ready, 0);

    // R5 fixed anchor: six-byte ASCII key "Secret", zero payload.
    ref_key = '{8'h53, 8'h65, 8'h63, 8'h72, 8'h65, 8'h74,
                0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    load_key(6);
    run_setup("R2 busy length");
    begin
      int exp_ks [8] = '{8'h04, 8'hD4, 8'h6B, 8'h05, 8'h3C, 8'hA8, 8'h7B, 8'h59};
      for (int m = 0; m < 8; m++) begin
        xfer(0, q, lat);
        check("R5 anchor keystream", q, exp_ks[m]);
      end
    end

    // R5 R6: sweep every legal key length with distinct keys and payloads.
    for (int len = 5; len <= 16; len++) begin
      for (int k = 0; k < 16; k++) ref_key[k] = (len * 37 + k * 11 + 1) & 8'hff;
      for (int m = 0; m < 12; m++) pt[m] = (m * 29 + len * 7) & 8'hff;
      load_key(len);
      run_setup("R2 busy length");
      run_frame(12, "R5 R6 keyed output");
    end

    // R6 clamping: requested 2 acts as 5, requested 31 acts as 16.
    for (int k = 0; k < 16; k++) ref_key[k] = (k * 53 + 9) & 8'hff;
    for (int m = 0; m < 10; m++) pt[m] = 8'hA5 ^ m;
    load_key(2);
    run_setup("R2 busy length");
    run_frame(10, "R6 short length clamp");
    load_key(31);
    run_setup("R2 busy length");
    run_frame(10, "R6 long length clamp");

    // R3 R7: start and key writes inside a running setup are ignored.
    for (int k = 0; k < 16; k++) ref_key[k] = (k * 19 + 200) & 8'hff;
    for (int m = 0; m < 16; m++) pt[m] = (m * 61 + 3) & 8'hff;
    load_key(9);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    start = 1'b1; key_we = 1'b1;
    for (int k = 0; k < 4; k++) begin
      key_idx = 4'(k); key_byte = 8'h5A; cnt++; @(negedge clk);
    end
    start = 1'b0; key_we = 1'b0;
    while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
    check("R3 setup not restarted", cnt, 1152);
    run_frame(16, "R7 key writes while busy ignored");

    // R9: restart with the same key, ciphertext decrypts to plaintext.
    for (int m = 0; m < 16; m++) begin int tmp = ct[m]; ct[m] = pt[m]; pt[m] = tmp; end
    run_setup("R9 setup repeated");
    run_frame(16, "R9 round trip");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule